// File: doc/BRIEF.md
# Accumulator Machine Instruction Decoder

This block sits between the program store and the datapath of a small accumulator machine with 4-bit data. Each instruction is one 8-bit byte. The upper nibble selects the operation. The lower nibble is an immediate value, a memory address or a page value, depending on the operation.

The block decodes the byte within the same cycle. It produces:
- an ALU function select and an operand-source select;
- write strobes for the accumulator, data memory, address latch and page register;
- a conditional jump request, with an 8-bit target formed from the page register and the operand.

Each instruction retires on the next rising clock edge. The block holds the architectural state: accumulator, carry flag, memory address latch, page register and the output-port register. Address all-ones is mapped to the I/O port, not to RAM: loads from it return the input port, and stores to it update the output port.

Top module: `acc4_decoder`

## Requirements
- R1: Opcode 0 adds the operand to the accumulator modulo 16. The carry-out is written to the carry flag, and `alu_sel` reads 1.
- R2: Opcode 2 loads the operand into the accumulator and leaves the carry flag unchanged. `alu_sel` reads 0 for every non-ALU opcode.
- R3: Opcode 3 loads the accumulator from memory at the latched address, with `src_mem` high. The operand nibble is ignored. When the latch holds F, the value comes from `in_port` and not from `mem_rdata`.
- R4: Opcode C pulses `latch_ld` and loads the operand into the address latch. For every opcode except a store, the latch drives `mem_addr`.
- R5: Opcode A stores the accumulator. `mem_addr` equals the operand, `mem_wdata` equals the accumulator, and `mem_we` is high. When the operand is F, `mem_we` stays low and `out_port` takes the accumulator on the next edge.
- R6: Opcode 8 raises `jump_req` only while the carry flag is 0. `jump_addr` is {page, operand}.
- R7: Opcode E pulses `page_ld` and writes the operand into the page register.
- R8: Opcode 4 writes the NAND of accumulator and operand, and `alu_sel` reads 2. Opcode 6 writes the XOR, and `alu_sel` reads 3. Neither changes the carry flag.
- R9: Opcodes 1, 5, 7, 9, B, D and F raise no strobe and change no state.
- R10: In any cycle, at most one of `acc_we`, `mem_we`, `latch_ld`, `page_ld` and `jump_req` is high.
- R11: A synchronous active-high reset clears the accumulator, carry, address latch, page register and output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 8 | Instruction byte: opcode in [7:4], operand in [3:0] |
| mem_rdata | input | 4 | Data memory read data at `mem_addr` |
| in_port | input | 4 | Input port value, read at address F |
| alu_sel | output | 2 | ALU function: 0 pass, 1 add, 2 nand, 3 xor |
| src_mem | output | 1 | ALU operand taken from memory/port rather than the immediate |
| acc_we | output | 1 | Accumulator write strobe |
| mem_we | output | 1 | Data memory write strobe |
| latch_ld | output | 1 | Address latch load strobe |
| page_ld | output | 1 | Page register load strobe |
| jump_req | output | 1 | Jump taken this cycle |
| jump_addr | output | 8 | Jump target {page, operand} |
| mem_addr | output | 4 | Data memory address |
| mem_wdata | output | 4 | Data memory write data |
| out_port | output | 4 | Output port register |
| acc_q | output | 4 | Accumulator |
| carry_q | output | 1 | Carry flag |
| page_q | output | 4 | Page register |

## Verification
The assertions check four things on every cycle:
- at most one strobe is active;
- a jump is only requested while carry is clear, and no RAM write goes to the port address;
- the accumulator and carry after an add match a 5-bit sum of the previous values, and page and output-port loads pick up the operand or accumulator of the previous cycle;
- a cycle with no strobes leaves the state untouched, and the state is cleared after reset.

Some behaviours only the bench scenarios can show:
- that the latched address steers a load to the input port;
- that the logic operations give the right values;
- that the jump target combines the page correctly;
- that each unused opcode behaves as a no-operation.

// File: rtl/acc4_pkg.sv
package acc4_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [1:0] {
      ALU_PASS = 2'd0,
      ALU_ADD  = 2'd1,
      ALU_NAND = 2'd2,
      ALU_XOR  = 2'd3
   } alu_sel_e;

   typedef enum logic [OPC_W-1:0] {
      OP_ADD  = 4'h0,
      OP_LDI  = 4'h2,
      OP_LDM  = 4'h3,
      OP_NAND = 4'h4,
      OP_XOR  = 4'h6,
      OP_JNC  = 4'h8,
      OP_STO  = 4'hA,
      OP_ADR  = 4'hC,
      OP_PAGE = 4'hE
   } opc_e;

   typedef struct packed {
      alu_sel_e alu;
      logic     src_mem;
      logic     acc_we;
      logic     carry_we;
      logic     store;
      logic     latch_ld;
      logic     page_ld;
      logic     jnc;
   } ctrl_t;

endpackage

// File: rtl/acc4_ctrl_dec.sv
module acc4_ctrl_dec
   import acc4_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output ctrl_t            ctrl
);

   always_comb begin
      ctrl = '0;
      ctrl.alu = ALU_PASS;
      case (opc)
         OP_ADD:  begin ctrl.alu = ALU_ADD;  ctrl.acc_we = 1'b1; ctrl.carry_we = 1'b1; end
         OP_LDI:  begin ctrl.acc_we = 1'b1; end
         OP_LDM:  begin ctrl.acc_we = 1'b1; ctrl.src_mem = 1'b1; end
         OP_NAND: begin ctrl.alu = ALU_NAND; ctrl.acc_we = 1'b1; end
         OP_XOR:  begin ctrl.alu = ALU_XOR;  ctrl.acc_we = 1'b1; end
         OP_JNC:  ctrl.jnc      = 1'b1;
         OP_STO:  ctrl.store    = 1'b1;
         OP_ADR:  ctrl.latch_ld = 1'b1;
         OP_PAGE: ctrl.page_ld  = 1'b1;
         default: ctrl = '0;
      endcase
   end

endmodule

// File: rtl/acc4_alu.sv
module acc4_alu
   import acc4_pkg::*;
#(
   parameter int W = 4
) (
   input  alu_sel_e     sel,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         cout
);

   logic [W:0] sum;

   always_comb begin
      sum  = {1'b0, a} + {1'b0, b};
      cout = sum[W];
      case (sel)
         ALU_ADD:  y = sum[W-1:0];
         ALU_NAND: y = ~(a & b);
         ALU_XOR:  y = a ^ b;
         default:  y = b;
      endcase
   end

endmodule

// File: rtl/acc4_decoder.sv
module acc4_decoder
   import acc4_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter int PAGE_W = 4,
   parameter bit IO_MAP = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [OPC_W+DATA_W-1:0]      instr,
   input  logic [DATA_W-1:0]            mem_rdata,
   input  logic [DATA_W-1:0]            in_port,
   output logic [1:0]                   alu_sel,
   output logic                         src_mem,
   output logic                         acc_we,
   output logic                         mem_we,
   output logic                         latch_ld,
   output logic                         page_ld,
   output logic                         jump_req,
   output logic [PAGE_W+DATA_W-1:0]     jump_addr,
   output logic [DATA_W-1:0]            mem_addr,
   output logic [DATA_W-1:0]            mem_wdata,
   output logic [DATA_W-1:0]            out_port,
   output logic [DATA_W-1:0]            acc_q,
   output logic                         carry_q,
   output logic [PAGE_W-1:0]            page_q
);

   localparam int INSTR_W = OPC_W + DATA_W;
   localparam logic [DATA_W-1:0] IO_ADDR = {DATA_W{1'b1}};

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("acc4_decoder: DATA_W must be at least 2");
      end
      if (PAGE_W < 1) begin : g_bad_page_w
         $error("acc4_decoder: PAGE_W must be at least 1");
      end
   endgenerate

   logic [OPC_W-1:0]  opc;
   logic [DATA_W-1:0] opnd;
   ctrl_t             ctrl;
   logic [DATA_W-1:0] latch_q;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] alu_b;
   logic [DATA_W-1:0] alu_y;
   logic              alu_c;
   logic              store_io;
   logic              out_we;

   assign opc  = instr[INSTR_W-1 -: OPC_W];
   assign opnd = instr[DATA_W-1:0];

   acc4_ctrl_dec i_dec (
      .opc  (opc),
      .ctrl (ctrl)
   );

   generate
      if (IO_MAP) begin : g_io
         assign rd_data  = (latch_q == IO_ADDR) ? in_port : mem_rdata;
         assign store_io = (opnd == IO_ADDR);
      end else begin : g_flat
         assign rd_data  = mem_rdata;
         assign store_io = 1'b0;
      end
   endgenerate

   assign alu_b = ctrl.src_mem ? rd_data : opnd;

   acc4_alu #(.W(DATA_W)) i_alu (
      .sel  (ctrl.alu),
      .a    (acc_q),
      .b    (alu_b),
      .y    (alu_y),
      .cout (alu_c)
   );

   assign alu_sel   = ctrl.alu;
   assign src_mem   = ctrl.src_mem;
   assign acc_we    = ctrl.acc_we;
   assign latch_ld  = ctrl.latch_ld;
   assign page_ld   = ctrl.page_ld;
   assign mem_we    = ctrl.store & ~store_io;
   assign out_we    = ctrl.store & store_io;
   assign jump_req  = ctrl.jnc & ~carry_q;
   assign jump_addr = {page_q, opnd};
   assign mem_addr  = ctrl.store ? opnd : latch_q;
   assign mem_wdata = acc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q    <= '0;
         carry_q  <= 1'b0;
         latch_q  <= '0;
         page_q   <= '0;
         out_port <= '0;
      end else begin
         if (ctrl.acc_we)   acc_q    <= alu_y;
         if (ctrl.carry_we) carry_q  <= alu_c;
         if (ctrl.latch_ld) latch_q  <= opnd;
         if (ctrl.page_ld)  page_q   <= opnd[PAGE_W-1:0];
         if (out_we)        out_port <= acc_q;
      end
   end

   // R1: accumulator and carry after an add form the 5-bit sum
   a_r1_add_sum: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(opc) == OP_ADD) |->
         ({carry_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(opnd)})));

   // R5: RAM is never written at the port address; port store lands next cycle
   a_r5_no_ram_io: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (mem_addr != IO_ADDR));
   a_r5_port_load: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(out_we)) |-> (out_port == $past(acc_q)));

   // R6: jump only while carry clear
   a_r6_jump_gate: assert property (@(posedge clk) disable iff (rst)
      jump_req |-> !carry_q);

   // R7: page register picks up the operand
   a_r7_page_load: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(page_ld)) |-> (page_q == $past(opnd[PAGE_W-1:0])));

   // R9: a cycle without strobes leaves the state untouched
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(acc_we) && !$past(page_ld) && !$past(out_we)) |->
         ($stable(acc_q) && $stable(carry_q) && $stable(page_q) && $stable(out_port)));

   // R10: one strobe at most
   a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
      $onehot0({acc_we, mem_we, latch_ld, page_ld, jump_req}));

   // R11: state cleared by reset
   a_r11_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (acc_q == '0 && !carry_q && page_q == '0 && out_port == '0));

endmodule

// File: tb/test_acc4_decoder.sv
`timescale 1ns/1ps
module test_acc4_decoder;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] instr = 8'h10;
   logic [3:0] mem_rdata = 4'h0;
   logic [3:0] in_port = 4'h0;
   logic [1:0] alu_sel;
   logic       src_mem, acc_we, mem_we, latch_ld, page_ld, jump_req;
   logic [7:0] jump_addr;
   logic [3:0] mem_addr, mem_wdata, out_port, acc_q, page_q;
   logic       carry_q;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   acc4_decoder i_acc4_decoder (
      .clk(clk), .rst(rst), .instr(instr), .mem_rdata(mem_rdata), .in_port(in_port),
      .alu_sel(alu_sel), .src_mem(src_mem), .acc_we(acc_we), .mem_we(mem_we),
      .latch_ld(latch_ld), .page_ld(page_ld), .jump_req(jump_req), .jump_addr(jump_addr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .out_port(out_port),
      .acc_q(acc_q), .carry_q(carry_q), .page_q(page_q)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(logic [3:0] o);
      case (o)
         4'h0: return "R1";
         4'h2: return "R2";
         4'h3: return "R3";
         4'h4, 4'h6: return "R8";
         4'h8: return "R6";
         4'hA: return "R5";
         4'hC: return "R4";
         4'hE: return "R7";
         default: return "R9";
      endcase
   endfunction

   // {instr, mem_rdata, in_port, alu_sel, {src_mem,acc_we,mem_we,latch_ld,page_ld,jump_req}, acc, carry, page, out_port}
   localparam int NV = 30;
   localparam logic [36:0] VEC [NV] = '{
      {8'h27, 4'h0, 4'h0, 2'd0, 6'b010000, 4'h7, 1'b0, 4'h0, 4'h0},
      {8'h0A, 4'h0, 4'h0, 2'd1, 6'b010000, 4'h1, 1'b1, 4'h0, 4'h0},
      {8'h83, 4'h0, 4'h0, 2'd0, 6'b000000, 4'h1, 1'b1, 4'h0, 4'h0},
      {8'h05, 4'h0, 4'h0, 2'd1, 6'b010000, 4'h6, 1'b0, 4'h0, 4'h0},
      {8'h83, 4'h0, 4'h0, 2'd0, 6'b000001, 4'h6, 1'b0, 4'h0, 4'h0},
      {8'hE9, 4'h0, 4'h0, 2'd0, 6'b000010, 4'h6, 1'b0, 4'h9, 4'h0},
      {8'h4C, 4'h0, 4'h0, 2'd2, 6'b010000, 4'hB, 1'b0, 4'h9, 4'h0},
      {8'h65, 4'h0, 4'h0, 2'd3, 6'b010000, 4'hE, 1'b0, 4'h9, 4'h0},
      {8'hA4, 4'h0, 4'h0, 2'd0, 6'b001000, 4'hE, 1'b0, 4'h9, 4'h0},
      {8'hAF, 4'h0, 4'h0, 2'd0, 6'b000000, 4'hE, 1'b0, 4'h9, 4'hE},
      {8'hC3, 4'h0, 4'h0, 2'd0, 6'b000100, 4'hE, 1'b0, 4'h9, 4'hE},
      {8'h30, 4'h5, 4'h9, 2'd0, 6'b110000, 4'h5, 1'b0, 4'h9, 4'hE},
      {8'hCF, 4'h5, 4'h9, 2'd0, 6'b000100, 4'h5, 1'b0, 4'h9, 4'hE},
      {8'h30, 4'h5, 4'h9, 2'd0, 6'b110000, 4'h9, 1'b0, 4'h9, 4'hE},
      {8'h1F, 4'h0, 4'h0, 2'd0, 6'b000000, 4'h9, 1'b0, 4'h9, 4'hE},
      {8'h5A, 4'h0, 4'h0, 2'd0, 6'b000000, 4'h9, 1'b0, 4'h9, 4'hE},
      {8'h7A, 4'h0, 4'h0, 2'd0, 6'b000000, 4'h9, 1'b0, 4'h9, 4'hE},
      {8'h9A, 4'h0, 4'h0, 2'd0, 6'b000000, 4'h9, 1'b0, 4'h9, 4'hE},
      {8'hBA, 4'h0, 4'h0, 2'd0, 6'b000000, 4'h9, 1'b0, 4'h9, 4'hE},
      {8'hDA, 4'h0, 4'h0, 2'd0, 6'b000000, 4'h9, 1'b0, 4'h9, 4'hE},
      {8'hFA, 4'h0, 4'h0, 2'd0, 6'b000000, 4'h9, 1'b0, 4'h9, 4'hE},
      {8'h2F, 4'h0, 4'h0, 2'd0, 6'b010000, 4'hF, 1'b0, 4'h9, 4'hE},
      {8'h01, 4'h0, 4'h0, 2'd1, 6'b010000, 4'h0, 1'b1, 4'h9, 4'hE},
      {8'h2A, 4'h0, 4'h0, 2'd0, 6'b010000, 4'hA, 1'b1, 4'h9, 4'hE},
      {8'h4F, 4'h0, 4'h0, 2'd2, 6'b010000, 4'h5, 1'b1, 4'h9, 4'hE},
      {8'h65, 4'h0, 4'h0, 2'd3, 6'b010000, 4'h0, 1'b1, 4'h9, 4'hE},
      {8'h83, 4'h0, 4'h0, 2'd0, 6'b000000, 4'h0, 1'b1, 4'h9, 4'hE},
      {8'h00, 4'h0, 4'h0, 2'd1, 6'b010000, 4'h0, 1'b0, 4'h9, 4'hE},
      {8'hE2, 4'h0, 4'h0, 2'd0, 6'b000010, 4'h0, 1'b0, 4'h2, 4'hE},
      {8'h87, 4'h0, 4'h0, 2'd0, 6'b000001, 4'h0, 1'b0, 4'h2, 4'hE}
   };

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      instr = 8'h10;
      #1;
      // R11: reset state
      check("R11", "acc after reset", acc_q, 4'h0);
      check("R11", "carry after reset", carry_q, 1'b0);
      check("R11", "page after reset", page_q, 4'h0);
      check("R11", "out_port after reset", out_port, 4'h0);
      check("R11", "latch after reset via mem_addr", mem_addr, 4'h0);
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         logic [36:0] v;
         string rq;
         v = VEC[k];
         instr = v[36:29];
         mem_rdata = v[28:25];
         in_port = v[24:21];
         rq = req_of(v[36:33]);
         #1;
         check(rq, $sformatf("alu_sel vec %0d", k), alu_sel, v[20:19]);
         check(rq, $sformatf("strobes vec %0d", k),
               {src_mem, acc_we, mem_we, latch_ld, page_ld, jump_req}, v[18:13]);
         check("R10", $sformatf("single strobe vec %0d", k),
               $countones({acc_we, mem_we, latch_ld, page_ld, jump_req}) <= 1, 1'b1);
         @(negedge clk);
         check(rq, $sformatf("acc vec %0d", k), acc_q, v[12:9]);
         check(rq, $sformatf("carry vec %0d", k), carry_q, v[8]);
         check(rq, $sformatf("page vec %0d", k), page_q, v[7:4]);
         check(rq, $sformatf("out_port vec %0d", k), out_port, v[3:0]);
      end

      // state: acc 0, carry 0, page 2, latch F, out E
      instr = 8'h87;
      #1;
      check("R6", "jump_addr", jump_addr, 8'h27);
      check("R6", "jump_req", jump_req, 1'b1);
      @(negedge clk);

      instr = 8'h2D;
      @(negedge clk);
      instr = 8'hA4;
      #1;
      check("R5", "store mem_addr", mem_addr, 4'h4);
      check("R5", "store mem_wdata", mem_wdata, 4'hD);
      check("R5", "store mem_we", mem_we, 1'b1);
      @(negedge clk);

      instr = 8'hAF;
      #1;
      check("R5", "port store mem_we", mem_we, 1'b0);
      @(negedge clk);
      check("R5", "port store out_port", out_port, 4'hD);

      instr = 8'h1F;
      #1;
      check("R4", "latch drives mem_addr", mem_addr, 4'hF);
      check("R9", "nop no mem_we", mem_we, 1'b0);
      @(negedge clk);

      // R11: reset mid-run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R11", "acc after mid reset", acc_q, 4'h0);
      check("R11", "page after mid reset", page_q, 4'h0);
      check("R11", "out_port after mid reset", out_port, 4'h0);
      check("R11", "latch after mid reset", mem_addr, 4'h0);

      finish_run();
   end

endmodule